// File: doc/BRIEF.md
# Serial DAC Register Interface

This block is the digital front end of a precision 20-bit digital-to-analog converter. A host drives a 3-wire serial port with an active-low frame sync, a serial clock and a data line. A tri-stateable data return line completes the port. All port inputs are oversampled in the system clock domain. Each 24-bit frame is taken MSB first. The frame is decoded when frame sync rises, and only then, into one of three actions: a register write, a readback request, or a no-op.

The block keeps a double-buffered pair of registers: an input register and a DAC register. The DAC register drives the 20-bit converter code and an output-clamp flag.

- A load strobe moves the input register into the DAC register. The strobe is either the load pin or a software bit.
- A clear strobe, from a pin or a software bit, loads a programmed clear code into the DAC register.
- A reset returns every register to its power-up state. In that state the output is clamped.

The receive machine has three states:

- `RX_IDLE` waits for frame sync to fall. Transition *frame start* goes to `RX_SHIFT`, loading any pending readback word into the output shifter.
- `RX_SHIFT` takes a bit on each serial clock falling edge and advances the return shifter on each rising edge. Transition *frame end* goes to `RX_EXEC` when frame sync rises, and issues the decode pulse.
- `RX_EXEC` turns the return driver off. Transition *settle* goes back to `RX_IDLE`.

Top module: `dac_serial_regif`

## Requirements
- R1: A frame is 24 bits, received MSB first on serial clock falling edges while frame sync is low, and is acted on only when frame sync rises. Bit 23 is the direction (1 = read, 0 = write), bits 22:20 the register address (0 no-op, 1 DAC, 2 control, 3 clear code, 4 software control), and bits 19:0 the data.
- R2: A frame that ends after any number of falling serial clock edges other than 24 changes no register.
- R3: A write to address 1 while the load input is low updates the DAC register, and therefore the code output, at the end of that frame.
- R4: A write to address 1 while the load input is high updates only the input register. A later falling edge of the load input copies the input register into the DAC register.
- R5: While the clear input is low, the DAC register is loaded with the clear code (address 3).
- R6: A low level on the reset input returns all registers to their power-up values. Those values are: input, DAC, clear code and control all zero, output clamped, and no readback pending.
- R7: After power-up or reset the clamp flag stays set until a written code first reaches the DAC register. Control bit 0 set to 1 also forces the clamp flag.
- R8: Control bit 1 selects the coding. At 0 (binary) the code output equals the DAC register. At 1 (two's complement) the code output equals the DAC register XOR 0x80000.
- R9: After a read frame naming address A, the next frame returns {1, A, value} MSB first on the data return line. The value is the DAC register for A=1, {18'b0, bit1, bit0} of control for A=2, the clear code for A=3, and zero otherwise.
- R10: The data return driver is enabled only during the frame that follows a read request, and is off again after frame sync rises. Its bits advance after serial clock rising edges.
- R11: A write to address 4 acts through data bits: bit 0 loads the input register into the DAC register, bit 1 loads the clear code, bit 2 resets every register. Reset beats clear, and clear beats load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sclk | input | 1 | Serial clock |
| fsync_n | input | 1 | Active-low frame sync |
| sdin | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, high impedance when disabled |
| sdo_oe | output | 1 | Enable of the serial data out driver |
| ldac_n | input | 1 | Active-low load strobe |
| clr_n | input | 1 | Active-low clear level |
| reset_n | input | 1 | Active-low register reset level |
| dac_code | output | 20 | Offset-binary code for the converter |
| out_clamp | output | 1 | Output clamped to ground when high |

## Verification
The bench sends frames of 23 and 25 bits. A design that counted loosely would commit them and move the code. It writes with the load pin high and then low. A design that ignored the pin would show the new code before the load edge, or would hold it back after the pin went low. Readbacks of the DAC, control and clear registers are placed after changes of coding and clamp, so a return word with shifted bit order, wrong address echo or stale contents shows up at once. The software control word is driven with both load and clear set, and with reset alone. A wrong priority or a partial reset leaves a code or clamp value that differs from the model.

// File: rtl/dsr_pkg.sv
`timescale 1ns/1ps
package dsr_pkg;
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_SHIFT = 2'd1,
        RX_EXEC  = 2'd2
    } rx_state_t;

    localparam int A_NOP  = 0;
    localparam int A_DAC  = 1;
    localparam int A_CTRL = 2;
    localparam int A_CLR  = 3;
    localparam int A_SWC  = 4;

    localparam int CB_CLAMP = 0;
    localparam int CB_TWOS  = 1;
    localparam int CTRL_W   = 2;

    localparam int SB_LOAD  = 0;
    localparam int SB_CLEAR = 1;
    localparam int SB_RESET = 2;
endpackage

// File: rtl/dsr_sync.sv
`timescale 1ns/1ps
module dsr_sync #(
    parameter int               WIDTH  = 1,
    parameter int               STAGES = 2,
    parameter logic [WIDTH-1:0] INIT   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= {STAGES{INIT}};
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/dsr_frame_rx.sv
`timescale 1ns/1ps
module dsr_frame_rx
    import dsr_pkg::*;
#(
    parameter int FRAME_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_s,
    input  logic               fs_s,
    input  logic               sdin_s,
    input  logic               rb_valid,
    input  logic [FRAME_W-1:0] rb_word,
    output logic               frm_end,
    output logic               frm_ok,
    output logic [FRAME_W-1:0] frm_word,
    output logic               sdo_bit,
    output logic               sdo_oe,
    output logic               rx_idle
);
    localparam int CNT_W = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

    rx_state_t          state, state_nx;
    logic               sclk_d, fs_d;
    logic               sclk_fall, sclk_rise, fs_fall, fs_rise;
    logic [CNT_W-1:0]   cnt;
    logic [FRAME_W-1:0] shin, shout;

    assign sclk_fall = sclk_d & ~sclk_s;
    assign sclk_rise = ~sclk_d & sclk_s;
    assign fs_fall   = fs_d & ~fs_s;
    assign fs_rise   = ~fs_d & fs_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b1;
            fs_d   <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            fs_d   <= fs_s;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE:  if (fs_fall) state_nx = RX_SHIFT;
            RX_SHIFT: if (fs_rise) state_nx = RX_EXEC;
            RX_EXEC:  state_nx = RX_IDLE;
            default:  state_nx = RX_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            shin    <= '0;
            shout   <= '0;
            sdo_oe  <= 1'b0;
            frm_end <= 1'b0;
            frm_ok  <= 1'b0;
        end else begin
            frm_end <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    if (fs_fall) begin
                        cnt    <= '0;
                        shin   <= '0;
                        shout  <= rb_word;
                        sdo_oe <= rb_valid;
                    end
                end
                RX_SHIFT: begin
                    if (sclk_fall) begin
                        shin <= {shin[FRAME_W-2:0], sdin_s};
                        if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
                    end
                    if (sclk_rise && cnt != '0) begin
                        shout <= {shout[FRAME_W-2:0], 1'b0};
                    end
                    if (fs_rise) begin
                        frm_end <= 1'b1;
                        frm_ok  <= (cnt == CNT_FULL);
                    end
                end
                RX_EXEC: begin
                    sdo_oe <= 1'b0;
                end
                default: sdo_oe <= 1'b0;
            endcase
        end
    end

    assign frm_word = shin;
    assign sdo_bit  = shout[FRAME_W-1];
    assign rx_idle  = (state == RX_IDLE);
endmodule

// File: rtl/dsr_regs.sv
`timescale 1ns/1ps
module dsr_regs
    import dsr_pkg::*;
#(
    parameter int  DATA_W  = 20,
    parameter int  ADDR_W  = 3,
    localparam int FRAME_W = 1 + ADDR_W + DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frm_end,
    input  logic               frm_ok,
    input  logic [FRAME_W-1:0] frm_word,
    input  logic               ldac_s,
    input  logic               clr_s,
    input  logic               hrst_s,
    output logic               rb_valid,
    output logic [FRAME_W-1:0] rb_word,
    output logic [DATA_W-1:0]  dac_code,
    output logic               out_clamp,
    output logic [DATA_W-1:0]  dac_q,
    output logic [DATA_W-1:0]  clr_q
);
    localparam logic [ADDR_W-1:0] AD_DAC  = ADDR_W'(A_DAC);
    localparam logic [ADDR_W-1:0] AD_CTRL = ADDR_W'(A_CTRL);
    localparam logic [ADDR_W-1:0] AD_CLR  = ADDR_W'(A_CLR);
    localparam logic [ADDR_W-1:0] AD_SWC  = ADDR_W'(A_SWC);
    localparam logic [DATA_W-1:0] SIGN_FLIP = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] in_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              pwr_q, pend_q, ldac_d, rb_pend;
    logic [ADDR_W-1:0] rb_addr;
    logic [DATA_W-1:0] rb_val;

    logic              is_rd, wr;
    logic [ADDR_W-1:0] f_addr;
    logic [DATA_W-1:0] f_data;
    logic              sw_wr, ldac_fall, do_reset, do_clear, do_load;

    assign is_rd     = frm_word[FRAME_W-1];
    assign f_addr    = frm_word[FRAME_W-2 -: ADDR_W];
    assign f_data    = frm_word[DATA_W-1:0];
    assign wr        = frm_end & frm_ok & ~is_rd;
    assign sw_wr     = wr & (f_addr == AD_SWC);
    assign ldac_fall = ldac_d & ~ldac_s;
    assign do_reset  = ~hrst_s | (sw_wr & f_data[SB_RESET]);
    assign do_clear  = ~clr_s | (sw_wr & f_data[SB_CLEAR]);
    assign do_load   = ldac_fall | (sw_wr & f_data[SB_LOAD]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ldac_d <= 1'b1;
        else        ldac_d <= ldac_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_q    <= '0;
            dac_q   <= '0;
            clr_q   <= '0;
            ctrl_q  <= '0;
            pwr_q   <= 1'b1;
            pend_q  <= 1'b0;
            rb_pend <= 1'b0;
            rb_addr <= '0;
        end else if (do_reset) begin
            in_q    <= '0;
            dac_q   <= '0;
            clr_q   <= '0;
            ctrl_q  <= '0;
            pwr_q   <= 1'b1;
            pend_q  <= 1'b0;
            rb_pend <= 1'b0;
            rb_addr <= '0;
        end else begin
            if (frm_end) begin
                rb_pend <= frm_ok & is_rd;
                rb_addr <= f_addr;
            end
            if (wr && f_addr == AD_CTRL) ctrl_q <= f_data[CTRL_W-1:0];
            if (wr && f_addr == AD_CLR)  clr_q  <= f_data;
            if (wr && f_addr == AD_DAC) begin
                in_q <= f_data;
                if (!ldac_s) begin
                    dac_q  <= f_data;
                    pwr_q  <= 1'b0;
                    pend_q <= 1'b0;
                end else begin
                    pend_q <= 1'b1;
                end
            end else if (do_load) begin
                dac_q <= in_q;
                if (pend_q) pwr_q <= 1'b0;
                pend_q <= 1'b0;
            end
            if (do_clear) dac_q <= clr_q;
        end
    end

    always_comb begin
        case (rb_addr)
            AD_DAC:  rb_val = dac_q;
            AD_CTRL: rb_val = DATA_W'(ctrl_q);
            AD_CLR:  rb_val = clr_q;
            default: rb_val = '0;
        endcase
    end

    assign rb_valid  = rb_pend;
    assign rb_word   = {1'b1, rb_addr, rb_val};
    assign dac_code  = ctrl_q[CB_TWOS] ? (dac_q ^ SIGN_FLIP) : dac_q;
    assign out_clamp = pwr_q | ctrl_q[CB_CLAMP];
endmodule

// File: rtl/dac_serial_regif.sv
`timescale 1ns/1ps
module dac_serial_regif #(
    parameter int DATA_W      = 20,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              fsync_n,
    input  logic              sdin,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic              ldac_n,
    input  logic              clr_n,
    input  logic              reset_n,
    output logic [DATA_W-1:0] dac_code,
    output logic              out_clamp
);
    localparam int FRAME_W = 1 + ADDR_W + DATA_W;
    localparam int N_IN    = 6;
    localparam logic [N_IN-1:0] IN_IDLE = 6'b110111;

    logic [N_IN-1:0]    raw_in, syn_in;
    logic               sclk_s, fs_s, sdin_s, ldac_s, clr_s, hrst_s;
    logic               rb_valid, frm_end, frm_ok, sdo_bit, rx_idle;
    logic [FRAME_W-1:0] rb_word, frm_word;
    logic [DATA_W-1:0]  dac_q, clr_q;

    assign raw_in = {sclk, fsync_n, sdin, ldac_n, clr_n, reset_n};
    assign {sclk_s, fs_s, sdin_s, ldac_s, clr_s, hrst_s} = syn_in;

    dsr_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES), .INIT(IN_IDLE)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
    );

    dsr_frame_rx #(.FRAME_W(FRAME_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .sclk_s(sclk_s), .fs_s(fs_s), .sdin_s(sdin_s),
        .rb_valid(rb_valid), .rb_word(rb_word),
        .frm_end(frm_end), .frm_ok(frm_ok), .frm_word(frm_word),
        .sdo_bit(sdo_bit), .sdo_oe(sdo_oe), .rx_idle(rx_idle)
    );

    dsr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .frm_end(frm_end), .frm_ok(frm_ok), .frm_word(frm_word),
        .ldac_s(ldac_s), .clr_s(clr_s), .hrst_s(hrst_s),
        .rb_valid(rb_valid), .rb_word(rb_word),
        .dac_code(dac_code), .out_clamp(out_clamp),
        .dac_q(dac_q), .clr_q(clr_q)
    );

    assign sdo = sdo_oe ? sdo_bit : 1'bz;
endmodule

// File: rtl/dsr_chk.sv
`timescale 1ns/1ps
module dsr_chk #(
    parameter int DATA_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_idle,
    input logic              sdo_oe,
    input logic              frm_end,
    input logic              frm_ok,
    input logic              hrst_s,
    input logic              clr_s,
    input logic              ldac_s,
    input logic [DATA_W-1:0] dac_q,
    input logic [DATA_W-1:0] clr_q,
    input logic              out_clamp,
    input logic [DATA_W-1:0] dac_code
);
    p_oe_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_idle |-> !sdo_oe);

    p_end_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frm_end |=> !frm_end);

    p_discard_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_end && !frm_ok && hrst_s && clr_s && $stable(ldac_s)) |=> $stable(dac_q));

    p_clear_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_s && hrst_s && !frm_end) |=> (dac_q == $past(clr_q)));

    p_reset_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !hrst_s |=> (out_clamp && dac_code == '0));

    p_clamp_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_clamp) |-> ($past(frm_end) || ($past(ldac_s, 2) && !$past(ldac_s))));
endmodule

bind dac_serial_regif dsr_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_idle(rx_idle), .sdo_oe(sdo_oe),
    .frm_end(frm_end), .frm_ok(frm_ok), .hrst_s(hrst_s), .clr_s(clr_s),
    .ldac_s(ldac_s), .dac_q(dac_q), .clr_q(clr_q),
    .out_clamp(out_clamp), .dac_code(dac_code)
);

// File: tb/sim_dac_serial_regif.sv
`timescale 1ns/1ps
module sim_dac_serial_regif;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b1, fsync_n = 1'b1, sdin = 1'b0;
    logic        ldac_n = 1'b1, clr_n = 1'b1, reset_n = 1'b1;
    wire         sdo;
    logic        sdo_oe;
    logic [19:0] dac_code;
    logic        out_clamp;

    int    n_chk = 0, n_fail = 0;
    bit    chk_en = 1'b0, done = 1'b0;
    string cur_req = "R6";

    // behavioural reference state
    logic [19:0] m_in, m_dac, m_clr;
    logic        m_twos, m_clen, m_pwr, m_pend, m_rbp;
    logic [2:0]  m_rba;

    always #5 clk = ~clk;

    dac_serial_regif u0 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .fsync_n(fsync_n), .sdin(sdin),
        .sdo(sdo), .sdo_oe(sdo_oe), .ldac_n(ldac_n), .clr_n(clr_n),
        .reset_n(reset_n), .dac_code(dac_code), .out_clamp(out_clamp)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] exp_code();
        return m_twos ? (m_dac ^ 20'h80000) : m_dac;
    endfunction

    function automatic logic [23:0] exp_rb();
        logic [19:0] v;
        case (m_rba)
            3'd1:    v = m_dac;
            3'd2:    v = {18'b0, m_twos, m_clen};
            3'd3:    v = m_clr;
            default: v = '0;
        endcase
        return {1'b1, m_rba, v};
    endfunction

    task automatic m_reset();
        m_in = '0; m_dac = '0; m_clr = '0; m_twos = 0; m_clen = 0;
        m_pwr = 1; m_pend = 0; m_rbp = 0; m_rba = '0;
    endtask

    task automatic m_transfer();
        m_dac = m_in;
        if (m_pend) m_pwr = 0;
        m_pend = 0;
    endtask

    task automatic m_frame(input logic [23:0] w, input int nbits);
        logic [19:0] d;
        d = w[19:0];
        if (nbits != 24) begin m_rbp = 0; return; end
        if (w[23]) begin m_rbp = 1; m_rba = w[22:20]; return; end
        m_rbp = 0;
        case (w[22:20])
            3'd1: begin
                m_in = d;
                if (ldac_n == 1'b0) begin m_dac = d; m_pwr = 0; m_pend = 0; end
                else m_pend = 1;
            end
            3'd2: begin m_clen = d[0]; m_twos = d[1]; end
            3'd3: m_clr = d;
            3'd4: begin
                if (d[2]) m_reset();
                else if (d[1]) m_dac = m_clr;
                else if (d[0]) m_transfer();
            end
            default: ;
        endcase
    endtask

    // every-clock comparison against the model while quiet
    always @(negedge clk) begin
        if (chk_en) begin
            chk({cur_req, " code"}, {12'b0, dac_code}, {12'b0, exp_code()});
            chk({cur_req, " clamp"}, {31'b0, out_clamp}, {31'b0, m_pwr | m_clen});
        end
    end

    task automatic send(input logic [23:0] w, input int nbits, input string req);
        logic [23:0] rd, erb;
        logic        eoe;
        bit          oe_ok;
        chk_en = 0; cur_req = req;
        eoe = m_rbp; erb = exp_rb(); rd = '0; oe_ok = 1;
        fsync_n = 0; tick(6);
        for (int i = 0; i < nbits; i++) begin
            sdin = (i < 24) ? w[23-i] : 1'b0;
            tick(6);
            if (i < 24) rd[23-i] = sdo_oe ? sdo : 1'b0;
            if (sdo_oe !== eoe) oe_ok = 0;
            sclk = 0; tick(6); sclk = 1;
        end
        tick(6); fsync_n = 1; tick(10);
        chk("R10 driver enable during frame", {31'b0, oe_ok}, 32'd1);
        if (eoe && nbits == 24) chk("R9 readback word", {8'b0, rd}, {8'b0, erb});
        chk("R10 driver off after frame sync rise", {31'b0, sdo_oe}, 32'd0);
        m_frame(w, nbits);
        chk_en = 1; tick(3);
    endtask

    task automatic set_ldac(input logic v);
        chk_en = 0;
        if (ldac_n == 1'b1 && v == 1'b0) begin ldac_n = 0; tick(10); m_transfer(); end
        else begin ldac_n = v; tick(10); end
        chk_en = 1; tick(2);
    endtask

    initial begin
        m_reset();
        tick(5); rst_n = 1; tick(10);
        // R6: power-up state
        chk("R6 reset code", {12'b0, dac_code}, 32'd0);
        chk("R7 clamped at power-up", {31'b0, out_clamp}, 32'd1);
        chk("R10 driver off at reset", {31'b0, sdo_oe}, 32'd0);
        chk_en = 1;

        // R4: buffered write with load high
        send({1'b0, 3'd1, 20'h12345}, 24, "R4");
        chk("R4 held in input register", {12'b0, dac_code}, 32'd0);
        chk("R7 still clamped before load", {31'b0, out_clamp}, 32'd1);
        cur_req = "R4"; set_ldac(0);
        chk("R4 load edge transfers", {12'b0, dac_code}, 32'h12345);
        chk("R7 clamp released by first load", {31'b0, out_clamp}, 32'd0);

        // R3: direct update with load held low; R1 bit order
        send({1'b0, 3'd1, 20'h80001}, 24, "R3");
        chk("R3 R1 direct update MSB first", {12'b0, dac_code}, 32'h80001);
        send({1'b0, 3'd1, 20'hABCDE}, 24, "R3");
        chk("R3 direct update", {12'b0, dac_code}, 32'hABCDE);

        // R2: wrong lengths discarded
        send({1'b0, 3'd1, 20'h00001}, 23, "R2");
        chk("R2 short frame ignored", {12'b0, dac_code}, 32'hABCDE);
        send({1'b0, 3'd1, 20'h00001}, 25, "R2");
        chk("R2 long frame ignored", {12'b0, dac_code}, 32'hABCDE);
        send({1'b0, 3'd2, 20'h00003}, 23, "R2");
        chk("R2 short control frame ignored", {31'b0, out_clamp}, 32'd0);

        // R8: two's complement coding
        send({1'b0, 3'd2, 20'h00002}, 24, "R8");
        chk("R8 twos coding flips MSB", {12'b0, dac_code}, 32'h2BCDE);

        // R9: readbacks
        send({1'b1, 3'd1, 20'h0}, 24, "R9");
        send(24'h000000, 24, "R9");
        send({1'b0, 3'd3, 20'h55AA5}, 24, "R9");
        send({1'b1, 3'd3, 20'h0}, 24, "R9");
        send(24'h000000, 24, "R9");
        send({1'b1, 3'd2, 20'h0}, 24, "R9");
        send(24'h000000, 24, "R10");

        // R5: clear pin
        chk_en = 0; cur_req = "R5"; clr_n = 0; tick(10); m_dac = m_clr; chk_en = 1; tick(4);
        chk("R5 clear loads clear code", {12'b0, dac_code}, 32'hD5AA5);
        chk_en = 0; clr_n = 1; tick(10); chk_en = 1; tick(2);

        // R11: software control
        set_ldac(1);
        send({1'b0, 3'd1, 20'h00777}, 24, "R11");
        send({1'b0, 3'd4, 20'h00001}, 24, "R11");
        chk("R11 software load", {12'b0, dac_code}, 32'h80777);
        send({1'b0, 3'd1, 20'h00123}, 24, "R11");
        send({1'b0, 3'd4, 20'h00003}, 24, "R11");
        chk("R11 clear beats load", {12'b0, dac_code}, 32'hD5AA5);
        send({1'b0, 3'd4, 20'h00004}, 24, "R11");
        chk("R11 software reset code", {12'b0, dac_code}, 32'd0);
        chk("R11 software reset clamps", {31'b0, out_clamp}, 32'd1);

        // R7: clamp enable bit
        set_ldac(0);
        send({1'b0, 3'd1, 20'h00400}, 24, "R7");
        chk("R7 clamp released", {31'b0, out_clamp}, 32'd0);
        send({1'b0, 3'd2, 20'h00001}, 24, "R7");
        chk("R7 clamp enable forces clamp", {31'b0, out_clamp}, 32'd1);
        send({1'b0, 3'd3, 20'h0F0F0}, 24, "R7");

        // R6: reset pin
        chk_en = 0; cur_req = "R6"; reset_n = 0; tick(10); m_reset(); chk_en = 1; tick(3);
        chk("R6 reset pin clamps", {31'b0, out_clamp}, 32'd1);
        chk_en = 0; reset_n = 1; tick(10); chk_en = 1;
        send({1'b1, 3'd3, 20'h0}, 24, "R6");
        send(24'h000000, 24, "R6");
        chk("R6 code after reset", {12'b0, dac_code}, 32'd0);

        chk_en = 0;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule